// File: doc/BRIEF.md
# Address Tenure Termination Controller

This block runs the master side of one bus address tenure. A start request taken while the controller is idle launches a tenure: the transfer-start strobe goes high for exactly one cycle. The address phase then lasts as long as the system withholds the address-acknowledge input. The cycle after the acknowledge is the last cycle of the retry window. In that cycle the controller reports how the tenure ended.

The address-retry input is watched from the point where a snooper may legally respond (a parameterised number of cycles after the strobe) until the end of the cycle after the acknowledge. A retry seen during the address phase is reported as an early retry. A retry seen for the first time in the cycle after the acknowledge is reported as a qualified retry. If no retry is seen, the tenure is reported as completed. While a retry is seen inside the window and a data tenure is running, an abort request goes out in the same cycle. A companion checker raises one flag per cycle for each of three protocol violations. Data movement, arbitration and re-issue of retried tenures belong to neighbouring blocks.

The states are IDLE, START, ADDR and POST, with these transitions:
- IDLE→START on a start request.
- START→ADDR always (strobe cycle).
- ADDR→ADDR while no acknowledge arrives.
- ADDR→POST on acknowledge.
- POST→IDLE always.

Top module: `addr_tenure_ctl`

## Requirements
- R1: After reset the controller is idle: strobe, busy, result-valid, abort and all violation flags are low, and the result code is 0.
- R2: A start request seen while idle raises `ts_o` for exactly the following cycle. Start requests seen while a tenure is under way have no effect.
- R3: `busy_o` is high from the strobe cycle through the cycle after the acknowledge. The address phase continues for as many cycles as the acknowledge is withheld.
- R4: An acknowledge on the strobe cycle does not end the tenure. The controller still waits for a later acknowledge.
- R5: A tenure with no qualifying retry reports result code 0 (completed).
- R6: A retry seen in the address phase, no earlier than SNOOP_LAT cycles after the strobe and up to and including the acknowledge cycle, yields result code 1 (early retry).
- R7: A retry seen first in the cycle after the acknowledge yields result code 2 (qualified retry).
- R8: `res_valid_o` is high for exactly one cycle, the cycle after the acknowledge. `res_kind_o` is 0 whenever `res_valid_o` is low.
- R9: `abort_o` is high in each cycle where retry is seen inside the window while `data_busy_i` is high, and low otherwise.
- R10: A retry asserted fewer than SNOOP_LAT cycles after the strobe is ignored: it neither raises `abort_o` nor changes the result.
- R11: `viol_o[0]` flags an acknowledge in the strobe cycle.
- R12: `viol_o[1]` flags an acknowledge that is high in two consecutive cycles. It is raised in the second cycle.
- R13: `viol_o[2]` flags each cycle, up to and including the cycle after the acknowledge, where retry is low after an early retry was recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req_i | input | 1 | Request to launch a tenure |
| aack_i | input | 1 | Address acknowledge from the system |
| artry_i | input | 1 | Address retry from a snooper |
| data_busy_i | input | 1 | A data tenure is in progress |
| ts_o | output | 1 | Transfer-start strobe |
| busy_o | output | 1 | Tenure in progress |
| res_valid_o | output | 1 | Result pulse, cycle after acknowledge |
| res_kind_o | output | 2 | 0 completed, 1 early retry, 2 qualified retry |
| abort_o | output | 1 | Terminate the running data tenure |
| viol_o | output | 3 | Protocol violation flags (bit 0 ack on strobe, bit 1 long ack, bit 2 retry released early) |

## Verification
The bench builds the block with SNOOP_LAT set to 3 rather than the default 2. With that setting, retries in the first and second cycles after the strobe fall in the ignored zone, while a minimum two-cycle tenure still reaches its result cycle. A long tenure with retry released in the fourth address cycle drives the snoop-delay counter into saturation. The reference model tracks each tenure as a phase, a cycle count and an early-retry flag, and it predicts every output on every cycle for completed, early, qualified, ignored and violating tenures.

// File: rtl/tenure_pkg.sv
package tenure_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_ADDR  = 2'd2,
        ST_POST  = 2'd3
    } ten_state_t;

    typedef enum logic [1:0] {
        RES_DONE  = 2'd0,
        RES_EARLY = 2'd1,
        RES_QUAL  = 2'd2
    } ten_res_t;

    localparam int VIOL_W = 3;

endpackage

// File: rtl/tenure_fsm.sv
module tenure_fsm
    import tenure_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req_i,
    input  logic       aack_i,
    output ten_state_t state_o,
    output logic       ts_o,
    output logic       busy_o,
    output logic       post_o
);

    ten_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req_i) state_d = ST_START;
            ST_START: state_d = ST_ADDR;            // ack here is ignored
            ST_ADDR:  if (aack_i) state_d = ST_POST;
            ST_POST:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ts_o   = 1'b0;
        busy_o = 1'b1;
        post_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_START: ts_o   = 1'b1;
            ST_ADDR:  ;
            ST_POST:  post_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    a_r2_ts_single: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> !ts_o);
    a_r4_ack_on_ts_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_o && aack_i) |=> (state_q == ST_ADDR));
    a_r8_post_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        post_o |-> $past(aack_i));

endmodule

// File: rtl/retry_track.sv
module retry_track
    import tenure_pkg::*;
#(
    parameter int SNOOP_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ten_state_t state_i,
    input  logic       artry_i,
    input  logic       data_busy_i,
    output logic       window_o,
    output logic       early_o,
    output logic       abort_o
);

    localparam int CNT_W = $clog2(SNOOP_LAT + 1);
    localparam logic [CNT_W-1:0] LAT_C = CNT_W'(SNOOP_LAT);

    logic [CNT_W-1:0] cyc_q;
    logic             early_q;
    logic             snoop_ok;

    assign snoop_ok = (cyc_q >= LAT_C);
    assign window_o = ((state_i == ST_ADDR) && snoop_ok) || (state_i == ST_POST);

    // cycles since strobe, saturating at the snoop latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q   <= '0;
            early_q <= 1'b0;
        end else begin
            unique case (state_i)
                ST_START: begin
                    cyc_q   <= CNT_W'(1);
                    early_q <= 1'b0;
                end
                ST_ADDR: begin
                    if (!snoop_ok) cyc_q <= cyc_q + CNT_W'(1);
                    if (artry_i && snoop_ok) early_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign early_o = early_q;
    assign abort_o = artry_i && window_o && data_busy_i;

    a_r9_abort_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> (data_busy_i && artry_i));
    a_r10_fresh_tenure: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_START) |=> !early_o);

endmodule

// File: rtl/tenure_checker.sv
module tenure_checker
    import tenure_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ten_state_t        state_i,
    input  logic              aack_i,
    input  logic              artry_i,
    input  logic              early_i,
    output logic [VIOL_W-1:0] viol_o
);

    logic aack_q;

    always_ff @(posedge clk) begin
        if (!rst_n) aack_q <= 1'b0;
        else        aack_q <= aack_i;
    end

    always_comb begin
        viol_o    = '0;
        viol_o[0] = (state_i == ST_START) && aack_i;
        viol_o[1] = aack_i && aack_q;
        viol_o[2] = ((state_i == ST_ADDR) || (state_i == ST_POST)) && early_i && !artry_i;
    end

endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl
    import tenure_pkg::*;
#(
    parameter int SNOOP_LAT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_req_i,
    input  logic        aack_i,
    input  logic        artry_i,
    input  logic        data_busy_i,
    output logic        ts_o,
    output logic        busy_o,
    output logic        res_valid_o,
    output logic [1:0]  res_kind_o,
    output logic        abort_o,
    output logic [2:0]  viol_o
);

    ten_state_t state;
    logic       post, window, early;
    ten_res_t   kind;

    tenure_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req_i (start_req_i),
        .aack_i      (aack_i),
        .state_o     (state),
        .ts_o        (ts_o),
        .busy_o      (busy_o),
        .post_o      (post)
    );

    retry_track #(.SNOOP_LAT(SNOOP_LAT)) u_rty (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .artry_i     (artry_i),
        .data_busy_i (data_busy_i),
        .window_o    (window),
        .early_o     (early),
        .abort_o     (abort_o)
    );

    tenure_checker u_chk (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (state),
        .aack_i  (aack_i),
        .artry_i (artry_i),
        .early_i (early),
        .viol_o  (viol_o)
    );

    // result classification in the last window cycle
    always_comb begin
        kind = RES_DONE;
        if (post && window) begin
            if (early)        kind = RES_EARLY;
            else if (artry_i) kind = RES_QUAL;
        end
    end

    assign res_valid_o = post;
    assign res_kind_o  = kind;

    a_r3_busy_after_ts: assert property (@(posedge clk) disable iff (!rst_n)
        ts_o |=> busy_o);
    a_r8_result_single: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    a_r8_kind_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (res_kind_o == 2'd0));

endmodule

// File: tb/sim_addr_tenure_ctl.sv
module sim_addr_tenure_ctl;

    localparam int PERIOD = 10;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, aack = 1'b0, artry = 1'b0, dbusy = 1'b0;
    logic ts, busy, rv, abort;
    logic [1:0] kind;
    logic [2:0] viol;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // reference model state
    int m_ph = 0;     // 0 idle, 1 strobe, 2 address, 3 after-ack
    int m_cnt = 0;
    int m_early = 0;
    int m_aprev = 0;

    always #(PERIOD/2) clk = ~clk;

    addr_tenure_ctl #(.SNOOP_LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req_i(start_req), .aack_i(aack),
        .artry_i(artry), .data_busy_i(dbusy), .ts_o(ts), .busy_o(busy),
        .res_valid_o(rv), .res_kind_o(kind), .abort_o(abort), .viol_o(viol)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic s, input logic a, input logic r, input logic d);
        int e_win, e_kind;
        start_req = s; aack = a; artry = r; dbusy = d;
        #1;
        e_win  = ((m_ph == 2 && m_cnt >= LAT) || m_ph == 3) ? 1 : 0;
        e_kind = 0;
        if (m_ph == 3) e_kind = m_early ? 1 : (r ? 2 : 0);
        cmp("R2 ts", int'(ts), (m_ph == 1) ? 1 : 0);
        cmp("R3 busy", int'(busy), (m_ph != 0) ? 1 : 0);
        cmp("R8 result valid", int'(rv), (m_ph == 3) ? 1 : 0);
        cmp("R5/R6/R7 result kind", int'(kind), e_kind);
        cmp("R9/R10 abort", int'(abort), (r && d && e_win) ? 1 : 0);
        cmp("R11 ack on strobe", int'(viol[0]), (m_ph == 1 && a) ? 1 : 0);
        cmp("R12 long ack", int'(viol[1]), (a && m_aprev) ? 1 : 0);
        cmp("R13 retry released", int'(viol[2]),
            ((m_ph == 2 || m_ph == 3) && m_early && !r) ? 1 : 0);
        // advance model
        m_aprev = a;
        case (m_ph)
            0: if (s) m_ph = 1;
            1: begin m_ph = 2; m_cnt = 1; m_early = 0; end
            2: begin
                if (r && m_cnt >= LAT) m_early = 1;
                if (m_cnt < LAT) m_cnt++;
                if (a) m_ph = 3;
            end
            default: m_ph = 0;
        endcase
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL R3 watchdog actual %0d expected %0d", cycles, 5000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle after reset
        step(0,0,0,0);
        step(0,0,0,0);
        // R5, R3: completed tenure, ack at third address cycle
        step(1,0,0,0); step(0,0,0,0); step(0,0,0,0); step(0,0,0,0);
        step(0,1,0,0); step(0,0,0,0); step(0,0,0,0);
        // R3: minimum two-cycle tenure
        step(1,0,0,0); step(0,0,0,0); step(0,1,0,0); step(0,0,0,0); step(0,0,0,0);
        // R6, R9: early retry with data tenure running
        step(1,0,0,0); step(0,0,0,0); step(0,0,0,1); step(0,0,0,1);
        step(0,0,1,1); step(0,1,1,1); step(0,0,1,0); step(0,0,0,0);
        // R7, R9: qualified retry
        step(1,0,0,0); step(0,0,0,0); step(0,0,0,1); step(0,1,0,1);
        step(0,0,1,1); step(0,0,0,0);
        // R10: retry before snoop latency is ignored
        step(1,0,0,0); step(0,0,0,0); step(0,0,1,1); step(0,0,1,1);
        step(0,0,0,1); step(0,1,0,1); step(0,0,0,0); step(0,0,0,0);
        // R4, R11: ack on strobe cycle
        step(1,0,0,0); step(0,1,0,0); step(0,0,0,0); step(0,1,0,0);
        step(0,0,0,0); step(0,0,0,0);
        // R12: ack held two cycles
        step(1,0,0,0); step(0,0,0,0); step(0,1,0,0); step(0,1,0,0);
        step(0,0,0,0); step(0,0,0,0);
        // R13: early retry released before window end
        step(1,0,0,0); step(0,0,0,0); step(0,0,0,0); step(0,0,0,0);
        step(0,0,1,0); step(0,0,0,0); step(0,1,0,0); step(0,0,0,0); step(0,0,0,0);
        // R2: start held during tenure is ignored
        step(1,0,0,0); step(1,0,0,0); step(1,0,0,0); step(1,1,0,0);
        step(0,0,0,0); step(0,0,0,0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule